// File: doc/BRIEF.md
# Three-Channel LED Pulse-Width Modulator

This block drives three LED current sinks with independent on/off duty patterns. A single free-running slot counter divides each PWM period into 32 equal slots, and each slot lasts a fixed number of system clocks set by a prescale parameter. The default of 15 clocks per slot gives a repetition rate of about 2.1 kHz from a 1 MHz clock. Each channel holds a 5-bit duty value. With duty d, the channel's output is high for the first d slots of every period. Each step is therefore about 3.125 % of on-time. Two codes are special: code 0 keeps the output dark, and code 31 keeps it lit for the whole period rather than 31/32 of it.

Software may write duty values at any time. A write first lands in a pending register. The value the comparator uses is loaded from that register only at the boundary between two periods, so a write in the middle of a period never produces a shortened or stretched pulse. A global run enable acts as the shutdown control. While it is low, every output is forced low and the counters are held at the start of a period. When it returns high, a fresh period begins at once and uses the latest duty values.

The block has no streaming data path. Writes are single-cycle strobes, and every pin is a plain control or status signal with no back-pressure.

Top module: `tri_led_pwm`

## Requirements
- R1: While `run_en` is high, a PWM period lasts 32 × PRESCALE clocks, and `period_start` is high for exactly the first clock of each period.
- R2: For a duty code d from 1 to 30, the output is high for the first d × PRESCALE clocks of the period and low for the rest.
- R3: Duty code 0 keeps the output low for the whole period.
- R4: Duty code 31 keeps the output high for all 32 × PRESCALE clocks of the period.
- R5: Bit i of `duty_we` loads `duty_wdata` into channel i (bit 0 controls `led_pwm[0]`). Channels whose strobe bit is clear keep their values, and several bits may be set in the same cycle.
- R6: A duty written while `run_en` is high takes effect from the next period start. The period in progress keeps the duty it began with.
- R7: While `run_en` is low, all outputs and `period_start` are low. In the first clock with `run_en` high again, `period_start` is high, and that period uses the duties written during the shutdown.
- R8: After reset, every duty value is 0, so all outputs stay low until duties are written.
- R9: While running, an output makes a low-to-high transition only in a clock where `period_start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Global enable. Low means shutdown. |
| duty_we | input | NUM_CH | Per-channel duty write strobes |
| duty_wdata | input | DUTY_W | Duty code written on a strobe |
| led_pwm | output | NUM_CH | Gate signals to the LED current sinks |
| period_start | output | 1 | High in the first clock of each period |

## Verification
The assertions assume that `run_en`, `duty_we` and `duty_wdata` are synchronous to `clk` and settle before each rising edge. They also assume that reset is held for at least one edge before any property is evaluated. The bench meets these assumptions by changing inputs only just after falling edges and by holding `rst_n` low for several clocks at start. It samples the outputs in the same place, away from the active edge. Duty writes land at chosen points: inside a period, at the boundary, and during shutdown. These placements exercise the runt-free loading rule without relying on race-prone timing.

// File: rtl/tri_led_pwm_pkg.sv
package tri_led_pwm_pkg;
  // Defaults shared by every module of the block
  parameter int unsigned DUTY_W_DEF   = 5;
  parameter int unsigned NUM_CH_DEF   = 3;
  parameter int unsigned PRESCALE_DEF = 15;  // 1 MHz / (32 * 15) ~= 2.08 kHz

  // Number of slots in one period for a given duty width
  function automatic int unsigned slots_for(input int unsigned w);
    return 32'd1 << w;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import tri_led_pwm_pkg::*;
#(
  parameter int unsigned PRESCALE = PRESCALE_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick,
  output logic phase0
);
  localparam int unsigned CNT_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  initial begin
    if (PRESCALE < 2) $error("PRESCALE must be at least 2");
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + ONE;
    end
  end

  assign tick   = en && (cnt == LAST);
  assign phase0 = (cnt == '0);

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R1
  cnt_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> phase0);
endmodule

// File: rtl/pwm_slot_counter.sv
module pwm_slot_counter
  import tri_led_pwm_pkg::*;
#(
  parameter int unsigned DUTY_W = DUTY_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  output logic [DUTY_W-1:0] slot,
  output logic              wrap
);
  localparam logic [DUTY_W-1:0] ONE  = DUTY_W'(1);
  localparam logic [DUTY_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      slot <= '0;
    end else if (tick) begin
      slot <= slot + ONE;  // 2**DUTY_W slots, natural wrap
    end
  end

  assign wrap = en && tick && (slot == LAST);

  // R1
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !tick |=> $stable(slot));

  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && tick |=> slot == ($past(slot) + ONE));

  // R7
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> slot == '0);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import tri_led_pwm_pkg::*;
#(
  parameter int unsigned DUTY_W = DUTY_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [DUTY_W-1:0] wdata,
  input  logic              wrap,
  input  logic [DUTY_W-1:0] slot,
  output logic              pwm
);
  localparam logic [DUTY_W-1:0] FULL = '1;

  logic [DUTY_W-1:0] pending;
  logic [DUTY_W-1:0] active;
  logic [DUTY_W-1:0] pending_nxt;

  assign pending_nxt = we ? wdata : pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
    end else begin
      pending <= pending_nxt;
    end
  end

  // Active value follows the pending one while idle, else only at a boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= '0;
    end else if (!en || wrap) begin
      active <= pending_nxt;
    end
  end

  assign pwm = en && ((active == FULL) || (slot < active));

  // R6
  hold_between_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !wrap |=> $stable(active));

  // R3
  dark_when_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !wrap && active == '0 |=> !pwm);
endmodule

// File: rtl/tri_led_pwm.sv
module tri_led_pwm
  import tri_led_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH   = NUM_CH_DEF,
  parameter int unsigned DUTY_W   = DUTY_W_DEF,
  parameter int unsigned PRESCALE = PRESCALE_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [NUM_CH-1:0] duty_we,
  input  logic [DUTY_W-1:0] duty_wdata,
  output logic [NUM_CH-1:0] led_pwm,
  output logic              period_start
);
  localparam int unsigned SLOTS = slots_for(DUTY_W);

  logic              tick;
  logic              phase0;
  logic              wrap;
  logic [DUTY_W-1:0] slot;

  pwm_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (run_en),
    .tick   (tick),
    .phase0 (phase0)
  );

  pwm_slot_counter #(.DUTY_W(DUTY_W)) u_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (run_en),
    .tick  (tick),
    .slot  (slot),
    .wrap  (wrap)
  );

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    pwm_channel #(.DUTY_W(DUTY_W)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (run_en),
      .we    (duty_we[gi]),
      .wdata (duty_wdata),
      .wrap  (wrap),
      .slot  (slot),
      .pwm   (led_pwm[gi])
    );

    // R9
    rise_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_en && $past(run_en) && $rose(led_pwm[gi]) |-> period_start);
  end

  assign period_start = run_en && phase0 && (slot == '0);

  initial begin
    if (SLOTS != 32) $display("note: period has %0d slots", SLOTS);
  end

  // R7
  shutdown_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (led_pwm == '0) && !period_start);

  // R1
  frame_follows_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && run_en |=> period_start || !run_en);
endmodule

// File: tb/tri_led_pwm_bench.sv
module tri_led_pwm_bench;
  localparam int N = 3;
  localparam int W = 5;
  localparam int P = 4;
  localparam int FRAME = 32 * P;
  localparam int NV = 8;
  localparam logic [W-1:0] VEC [NV][N] = '{
    '{5'd0,  5'd31, 5'd15},
    '{5'd1,  5'd30, 5'd2 },
    '{5'd31, 5'd31, 5'd31},
    '{5'd0,  5'd0,  5'd0 },
    '{5'd16, 5'd8,  5'd4 },
    '{5'd29, 5'd3,  5'd31},
    '{5'd7,  5'd0,  5'd22},
    '{5'd30, 5'd1,  5'd0 }
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run_en = 1'b1;
  logic [N-1:0] duty_we = '0;
  logic [W-1:0] duty_wdata = '0;
  logic [N-1:0] led_pwm;
  logic         period_start;

  int tests = 0;
  int fails = 0;
  int hi [N];
  int first_on [N];

  always #10 clk = ~clk;

  tri_led_pwm #(.NUM_CH(N), .DUTY_W(W), .PRESCALE(P)) u_tri_led_pwm (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .duty_we(duty_we),
    .duty_wdata(duty_wdata), .led_pwm(led_pwm), .period_start(period_start)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic write_duty(input logic [N-1:0] mask, input logic [W-1:0] val);
    duty_we = mask;
    duty_wdata = val;
    step();
    duty_we = '0;
  endtask

  task automatic wait_frame();
    step();
    while (!period_start) step();
  endtask

  // Starts on a period_start sample; ends on the next one
  task automatic measure(input int mid_at, input int mid_ch, input logic [W-1:0] mid_val);
    for (int c = 0; c < N; c++) begin
      hi[c] = 0;
      first_on[c] = led_pwm[c];
    end
    for (int k = 0; k < FRAME; k++) begin
      for (int c = 0; c < N; c++) hi[c] += int'(led_pwm[c]);
      if (k == mid_at) begin
        duty_we = N'(1 << mid_ch);
        duty_wdata = mid_val;
      end
      step();
      duty_we = '0;
    end
  endtask

  function automatic int exp_hi(input int d);
    return (d == 31) ? FRAME : d * P;
  endfunction

  initial begin
    #(20 * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int gap;
    int seen;
    // R8: reset state
    repeat (4) step();
    chk("R8 outputs low in reset", int'(led_pwm), 0);
    rst_n = 1'b1;
    wait_frame();
    measure(-1, 0, '0);
    for (int c = 0; c < N; c++) chk("R8 duty zero after reset", hi[c], 0);

    // R1: period length
    gap = 0;
    do begin step(); gap++; end while (!period_start);
    chk("R1 period length", gap, FRAME);

    // R2 R3 R4: vector table
    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < N; c++) write_duty(N'(1 << c), VEC[v][c]);
      wait_frame();
      measure(-1, 0, '0);
      for (int c = 0; c < N; c++) begin
        chk("R2/R3/R4 on-time", hi[c], exp_hi(int'(VEC[v][c])));
        chk("R2 starts at period start", first_on[c], (VEC[v][c] != 0) ? 1 : 0);
      end
    end

    // R6: mid-period write keeps the current period
    write_duty(3'b111, 5'd10);
    wait_frame();
    measure(5 * P + 1, 0, 5'd20);
    chk("R6 current period unchanged", hi[0], 10 * P);
    measure(-1, 0, '0);
    chk("R6 new duty next period", hi[0], 20 * P);

    // R5: single and multi-bit strobes
    write_duty(3'b010, 5'd9);
    wait_frame();
    measure(-1, 0, '0);
    chk("R5 ch0 untouched", hi[0], 20 * P);
    chk("R5 ch1 written", hi[1], 9 * P);
    chk("R5 ch2 untouched", hi[2], 10 * P);
    write_duty(3'b101, 5'd3);
    wait_frame();
    measure(-1, 0, '0);
    chk("R5 ch0 multi", hi[0], 3 * P);
    chk("R5 ch1 kept", hi[1], 9 * P);
    chk("R5 ch2 multi", hi[2], 3 * P);

    // R7: shutdown and restart
    write_duty(3'b001, 5'd31);
    write_duty(3'b010, 5'd0);
    write_duty(3'b100, 5'd17);
    wait_frame();
    repeat (40) step();
    run_en = 1'b0;
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      step();
      seen += int'(led_pwm != '0) + int'(period_start);
      if (k == 5) write_duty(3'b010, 5'd5);
    end
    chk("R7 dark while shut down", seen, 0);
    step();
    run_en = 1'b1;
    #1;
    chk("R7 restart opens period", int'(period_start), 1);
    measure(-1, 0, '0);
    chk("R7/R4 ch0 full on", hi[0], FRAME);
    chk("R7 ch1 uses shutdown write", hi[1], 5 * P);
    chk("R7 ch2 duty", hi[2], 17 * P);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule